// File: doc/BRIEF.md
# Byte-Serializing I/O Bridge

This block sits between a 32-bit I/O requester and a small peripheral that only understands single-byte accesses through a 2-bit register offset. One request at a time is taken over a valid/ready handshake. Each request carries an address, a 4-bit lane mask, a 32-bit write word and a direction flag. The bridge walks the enabled lanes from the lowest one upward and issues one strobed byte access per lane. Between two accesses it puts one cycle with the strobe low.

On a read, each returned byte is put back into the lane it belongs to, so the requester gets a normal 32-bit word. Lanes that were not enabled read as zero. A request whose lane mask is empty or has holes is refused with an error and never reaches the peripheral. The same applies to a request that touches a byte outside the four-byte address window. Every request, good or bad, ends with a one-cycle completion pulse. A fixed quiet period follows the pulse, and during it the bridge takes no new request.

Top module: `io_byte_bridge`

## Requirements
- R1: A lane mask of 0x0, 0x5, 0x9, 0xA, 0xB or 0xD (empty, or with a disabled lane between two enabled lanes) completes with `done_err`=1 and gives no strobe on `slv_rd` or `slv_wr`.
- R2: Byte access k (counting from 0) of a legal request drives `slv_addr` = bits [1:0] of (`req_addr` + lowest enabled lane index + k). Bit 0 of `req_be` is lane 0, which holds `req_wdata[7:0]`.
- R3: A legal request produces exactly as many strobes as there are set bits in `req_be`.
- R4: Each strobe is high for exactly one cycle and is followed by at least one cycle with both strobes low. `slv_rd` and `slv_wr` are never high together.
- R5: During write access k, `slv_wdata` equals lane (lowest enabled lane + k) of `req_wdata`, which is byte bits [8L+7:8L] for lane L.
- R6: On a read, the byte on `slv_rdata` in the cycle after strobe k appears in `done_rdata` at lane (lowest enabled lane + k). Every other lane of `done_rdata` is zero, and `done_rdata` is all zero for writes and refused requests.
- R7: Each byte address (`req_addr` + enabled lane) must lie in 0x40 to 0x43. A request that breaks this completes with `done_err`=1 and no strobe.
- R8: After the cycle in which `done` is high, `req_ready` stays low for exactly 5 cycles and then rises.
- R9: `req_ready` is high only while the bridge is idle. A request held on `req_valid` while `req_ready` is low is not taken, and it causes no strobe until it is accepted.
- R10: A synchronous active-high `rst` brings the bridge to idle: `req_ready`=1, both strobes low, `done`=0, and the read word cleared.
- R11: `done` is high for exactly one cycle per accepted request, and `done_err` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle; a request is taken in this cycle |
| req_addr | input | 16 | Byte address of lane 0 |
| req_be | input | 4 | Lane mask, bit L enables lane L |
| req_wdata | input | 32 | Write word, lane L in bits [8L+7:8L] |
| req_write | input | 1 | 1 for write, 0 for read |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request refused (mask or window) |
| done_rdata | output | 32 | Reassembled read word, valid with `done` |
| slv_addr | output | 2 | Peripheral register offset |
| slv_rd | output | 1 | Peripheral read strobe |
| slv_wr | output | 1 | Peripheral write strobe |
| slv_wdata | output | 8 | Peripheral write byte |
| slv_rdata | input | 8 | Peripheral read byte, valid the cycle after `slv_rd` |

## Verification
In the strobe-low cycle between two bytes, two things happen at once: the bridge captures the byte returned for the previous access, and it already shows the next offset. Multi-byte reads against a bench peripheral that holds a different value at every offset make these two events meet in the same cycle. Any slip in capture or lane placement then shows up as a byte in the wrong lane of `done_rdata`, and the scoreboard compares that word with one built from its own memory model. The next request is held on `req_valid` all through the cool-down, so the quiet period and the hand-off from one transaction to the next also run concurrently.

// File: rtl/iobb_pkg.sv
package iobb_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_GAP,
        ST_FIN,
        ST_COOL
    } seq_state_e;

    typedef struct packed {
        logic [LANE_W-1:0] first;
        logic [CNT_W-1:0]  cnt;
        logic              be_bad;
        logic              win_bad;
    } req_plan_t;

    function automatic logic [LANE_W-1:0] f_first_lane(input logic [LANES-1:0] be);
        logic [LANE_W-1:0] r;
        r = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (be[i]) r = LANE_W'(i);
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] f_popcount(input logic [LANES-1:0] be);
        logic [CNT_W-1:0] r;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            r = r + CNT_W'(be[i]);
        end
        return r;
    endfunction

    function automatic logic f_be_legal(input logic [LANES-1:0] be);
        logic [LANES:0] norm;
        norm = {1'b0, be} >> f_first_lane(be);
        return (be != '0) && ((norm & (norm + 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/iobb_req_decode.sv
module iobb_req_decode
    import iobb_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output req_plan_t         plan
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W + 1)'(LANES - 1);

    logic [LANE_W-1:0] first;
    logic [CNT_W-1:0]  cnt;
    logic              legal;
    logic [ADDR_W:0]   start_a;
    logic [ADDR_W:0]   last_a;

    always_comb begin
        first   = f_first_lane(be);
        cnt     = f_popcount(be);
        legal   = f_be_legal(be);
        start_a = {1'b0, addr} + (ADDR_W + 1)'(first);
        last_a  = start_a + (ADDR_W + 1)'(cnt) - (ADDR_W + 1)'(1);
        plan.first   = first;
        plan.cnt     = cnt;
        plan.be_bad  = !legal;
        plan.win_bad = legal && ((start_a < WIN_LO) || (last_a > WIN_HI));
    end

endmodule

// File: rtl/iobb_rd_gather.sv
module iobb_rd_gather
    import iobb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_en,
    input  logic [LANE_W-1:0] cap_lane,
    input  logic [BYTE_W-1:0] cap_byte,
    output logic [DATA_W-1:0] word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                word[g*BYTE_W +: BYTE_W] <= '0;
            end else if (cap_en && (cap_lane == LANE_W'(g))) begin
                word[g*BYTE_W +: BYTE_W] <= cap_byte;
            end
        end
    end

endmodule

// File: rtl/iobb_seq.sv
module iobb_seq
    import iobb_pkg::*;
#(
    parameter int GAP_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  req_plan_t         plan,
    output logic [LANE_W-1:0] slv_addr,
    output logic              slv_rd,
    output logic              slv_wr,
    output logic [BYTE_W-1:0] slv_wdata,
    output logic              done,
    output logic              done_err,
    output logic              acc_clr,
    output logic              cap_en,
    output logic [LANE_W-1:0] cap_lane
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    seq_state_e        state;
    logic              is_wr;
    logic              err_q;
    logic [CNT_W-1:0]  remain;
    logic [LANE_W-1:0] off;
    logic [LANE_W-1:0] lane_q;
    logic [DATA_W-1:0] data_sh;
    logic [GAP_W-1:0]  cool_cnt;
    logic              accept;
    logic              bad;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign bad       = plan.be_bad || plan.win_bad;
    assign acc_clr   = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            is_wr    <= 1'b0;
            err_q    <= 1'b0;
            remain   <= '0;
            off      <= '0;
            lane_q   <= '0;
            data_sh  <= '0;
            cool_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        is_wr  <= req_write;
                        err_q  <= bad;
                        remain <= plan.cnt;
                        off    <= addr_lo + plan.first;
                        lane_q <= plan.first;
                        data_sh <= req_wdata >> {plan.first, 3'b000};
                        state  <= bad ? ST_FIN : ST_ACT;
                    end
                end
                ST_ACT: begin
                    remain  <= remain - 1'b1;
                    off     <= off + 1'b1;
                    data_sh <= data_sh >> BYTE_W;
                    state   <= ST_GAP;
                end
                ST_GAP: begin
                    lane_q <= lane_q + 1'b1;
                    state  <= (remain == '0) ? ST_FIN : ST_ACT;
                end
                ST_FIN: begin
                    cool_cnt <= '0;
                    state    <= ST_COOL;
                end
                ST_COOL: begin
                    cool_cnt <= cool_cnt + 1'b1;
                    if (cool_cnt == GAP_W'(GAP_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign slv_addr  = off;
    assign slv_rd    = (state == ST_ACT) && !is_wr;
    assign slv_wr    = (state == ST_ACT) && is_wr;
    assign slv_wdata = data_sh[BYTE_W-1:0];
    assign done      = (state == ST_FIN);
    assign done_err  = (state == ST_FIN) && err_q;
    assign cap_en    = (state == ST_GAP) && !is_wr;
    assign cap_lane  = lane_q;

    // R1 / R7: a refused request reaches no strobe
    p_bad_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && bad) |=> !(slv_rd || slv_wr));

    // R2: first access lands on the lowest enabled lane's offset
    p_first_off_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !bad) |=> (slv_addr == $past(addr_lo + plan.first)));

    p_strobe_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (slv_rd || slv_wr) |=> !(slv_rd || slv_wr));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(slv_rd && slv_wr));

    p_cool_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !req_ready);

    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(slv_rd || slv_wr || done));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/io_byte_bridge.sv
module io_byte_bridge
    import iobb_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040,
    parameter int                GAP_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] done_rdata,
    output logic [LANE_W-1:0] slv_addr,
    output logic              slv_rd,
    output logic              slv_wr,
    output logic [BYTE_W-1:0] slv_wdata,
    input  logic [BYTE_W-1:0] slv_rdata
);
    req_plan_t         plan;
    logic              acc_clr;
    logic              cap_en;
    logic [LANE_W-1:0] cap_lane;

    iobb_req_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .addr (req_addr),
        .be   (req_be),
        .plan (plan)
    );

    iobb_seq #(
        .GAP_CYC (GAP_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .addr_lo   (req_addr[LANE_W-1:0]),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .plan      (plan),
        .slv_addr  (slv_addr),
        .slv_rd    (slv_rd),
        .slv_wr    (slv_wr),
        .slv_wdata (slv_wdata),
        .done      (done),
        .done_err  (done_err),
        .acc_clr   (acc_clr),
        .cap_en    (cap_en),
        .cap_lane  (cap_lane)
    );

    iobb_rd_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .clr      (acc_clr),
        .cap_en   (cap_en),
        .cap_lane (cap_lane),
        .cap_byte (slv_rdata),
        .word     (done_rdata)
    );

endmodule

// File: tb/test_io_byte_bridge.sv
module test_io_byte_bridge;

    typedef struct {
        logic [31:0]      rdata;
        logic             err;
        int               nstb;
        logic             wr;
        logic [3:0][1:0]  addrs;
        logic [3:0][7:0]  wbytes;
        string            etag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        done;
    logic        done_err;
    logic [31:0] done_rdata;
    logic [1:0]  slv_addr;
    logic        slv_rd;
    logic        slv_wr;
    logic [7:0]  slv_wdata;
    logic [7:0]  slv_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    exp_t sbq[$];
    logic [7:0] bmem [4];
    logic [7:0] smem [4];

    always #10 clk = ~clk;

    io_byte_bridge i_io_byte_bridge (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_write(req_write),
        .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .slv_addr(slv_addr), .slv_rd(slv_rd), .slv_wr(slv_wr),
        .slv_wdata(slv_wdata), .slv_rdata(slv_rdata)
    );

    // peripheral model: registered read data, valid the cycle after the strobe
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) smem[i] <= 8'h51 + 8'(i * 17);
            slv_rdata <= '0;
        end else begin
            if (slv_wr) smem[slv_addr] <= slv_wdata;
            if (slv_rd) slv_rdata <= smem[slv_addr];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit mask_ok(input logic [3:0] be);
        bit seen = 0;
        bit hole = 0;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                if (hole) return 0;
                seen = 1;
            end else if (seen) begin
                hole = 1;
            end
        end
        return seen;
    endfunction

    task automatic do_req(input logic [15:0] a, input logic [3:0] be, input logic [31:0] wd,
                          input logic wr, input string etag);
        exp_t e;
        int   k;
        bit   ok;
        e.rdata = '0; e.wr = wr; e.nstb = 0; e.addrs = '0; e.wbytes = '0; e.etag = etag;
        ok = mask_ok(be);
        if (ok) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l] && ((a + 16'(l) < 16'h0040) || (a + 16'(l) > 16'h0043))) ok = 0;
            end
        end
        e.err = !ok;
        if (ok) begin
            k = 0;
            for (int l = 0; l < 4; l++) begin
                if (be[l]) begin
                    e.addrs[k] = 2'(a + 16'(l));
                    e.wbytes[k] = wd[l*8 +: 8];
                    if (wr) bmem[2'(a + 16'(l))] = wd[l*8 +: 8];
                    else    e.rdata[l*8 +: 8] = bmem[2'(a + 16'(l))];
                    k++;
                end
            end
            e.nstb = k;
        end
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_be = be; req_wdata = wd; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    int  stb_n = 0;
    bit  addr_bad = 0;
    bit  wd_bad = 0;
    bit  alt_bad = 0;
    bit  prev_stb = 0;
    bit  prev_done = 0;
    bit  cooling = 0;
    int  cool_n = 0;
    logic [31:0] last_bad_val = '0;

    initial begin
        exp_t e;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            if (slv_rd && slv_wr) alt_bad = 1;
            if ((slv_rd || slv_wr) && prev_stb) alt_bad = 1;
            if (slv_rd || slv_wr) begin
                if (sbq.size() == 0) begin
                    chk(0, "R9 strobe with no accepted request", 32'(slv_addr), 32'hx);
                end else begin
                    e = sbq[0];
                    if (stb_n < 4) begin
                        if (slv_addr != e.addrs[stb_n]) begin addr_bad = 1; last_bad_val = 32'(slv_addr); end
                        if (slv_wr && slv_wdata != e.wbytes[stb_n]) wd_bad = 1;
                    end
                end
                stb_n++;
            end
            prev_stb = slv_rd || slv_wr;

            if (cooling) begin
                if (req_ready) begin
                    chk(cool_n == 5, "R8 quiet cycles after done", 32'(cool_n), 32'd5);
                    cooling = 0;
                end else begin
                    cool_n++;
                end
            end

            if (done && prev_done) chk(0, "R11 done longer than one cycle", 32'd2, 32'd1);
            if (done && !prev_done) begin
                if (sbq.size() == 0) begin
                    chk(0, "R11 done with empty scoreboard", 32'd1, 32'd0);
                end else begin
                    e = sbq.pop_front();
                    chk(done_err == e.err, e.etag, 32'(done_err), 32'(e.err));
                    chk(done_rdata == e.rdata, "R6 assembled word", done_rdata, e.rdata);
                    chk(stb_n == e.nstb, "R3 strobe count", 32'(stb_n), 32'(e.nstb));
                    chk(!addr_bad, "R2 byte offset order", last_bad_val, 32'(e.addrs[0]));
                    if (e.wr) chk(!wd_bad, "R5 write byte", 32'(wd_bad), 32'd0);
                    chk(!alt_bad, "R4 strobe spacing", 32'(alt_bad), 32'd0);
                end
                stb_n = 0; addr_bad = 0; wd_bad = 0; alt_bad = 0;
                cooling = 1; cool_n = 0;
            end
            prev_done = done;
            @(negedge clk);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) bmem[i] = 8'h51 + 8'(i * 17);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);
        chk(!slv_rd && !slv_wr, "R10 strobes low after reset", {slv_rd, slv_wr}, 32'd0);
        chk(done == 1'b0, "R10 done low after reset", 32'(done), 32'd0);

        do_req(16'h0040, 4'hF, 32'h44332211, 1'b0, "R6 full read err");
        do_req(16'h0040, 4'hF, 32'hD4C3B2A1, 1'b1, "R5 full write err");
        do_req(16'h0040, 4'hF, 32'h0, 1'b0, "R6 readback err");
        do_req(16'h0040, 4'h6, 32'hAABBCCDD, 1'b1, "R2 middle write err");
        do_req(16'h0040, 4'hC, 32'h0, 1'b0, "R6 upper read err");
        do_req(16'h0043, 4'h1, 32'h0, 1'b0, "R7 last byte err");
        do_req(16'h0040, 4'h0, 32'h0, 1'b0, "R1 empty mask");
        do_req(16'h0040, 4'h5, 32'h12345678, 1'b1, "R1 mask 5");
        do_req(16'h0040, 4'h9, 32'h0, 1'b0, "R1 mask 9");
        do_req(16'h0040, 4'hA, 32'h0, 1'b0, "R1 mask A");
        do_req(16'h0040, 4'hB, 32'h0, 1'b1, "R1 mask B");
        do_req(16'h0040, 4'hD, 32'h0, 1'b0, "R1 mask D");
        do_req(16'h0041, 4'hF, 32'h0, 1'b0, "R7 past top");
        do_req(16'h003F, 4'h1, 32'h0, 1'b1, "R7 below base");
        do_req(16'h003F, 4'h2, 32'h0, 1'b0, "R7 shifted lane ok");
        do_req(16'h003D, 4'h8, 32'h77000000, 1'b1, "R2 high lane write ok");
        do_req(16'h003D, 4'hE, 32'h0, 1'b0, "R7 partial below base");
        do_req(16'h0040, 4'h3, 32'h0, 1'b0, "R6 low pair read err");
        do_req(16'h0041, 4'h7, 32'h00EEDDCC, 1'b1, "R5 offset write err");
        do_req(16'h0040, 4'hF, 32'h0, 1'b0, "R6 final read err");

        while (sbq.size() != 0 || cooling) @(negedge clk);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule